// File: doc/BRIEF.md
# Recursive Sinusoid Resonator

This block generates a sampled sinusoid with a two-tap recursive difference equation. Each new sample is the previous sample multiplied by a programmable coefficient, minus the sample before that. When the coefficient equals 2·cos W, where W = 2π·f_out/f_sample, the sequence is a pure tone at f_out. Each sample needs one fixed-point multiply and one subtraction.

The amplitude A and the phase come from the two state values loaded with the coefficient. Loading y[n−1] = 0 and y[n−2] = −A·sin W gives y[n] = A·sin(W·(n+1)). The cosine and sine for a requested frequency are computed outside the block. The block holds only the coefficient, the two state registers, the multiply with its rounding, and the saturating subtraction.

Samples are signed 16-bit Q1.15. The coefficient is signed 16-bit Q2.14, so it covers [−2, 2). A load strobe writes all three registers. A sample enable advances the recursion by one step.

Top module: `res_osc`

## Requirements
- R1: While rst_ni is low, y_o is 0 and valid_o is 0. After reset the coefficient and both state registers are 0.
- R2: On a clock edge with load_i high, three registers are written in that one cycle:
  - the coefficient from coef_i;
  - y[n−1] from init_prev_i;
  - y[n−2] from init_prev2_i.

  After that edge, y_o shows the loaded y[n−1] and valid_o is 0. The first enabled step uses the loaded values.
- R3: On a clock edge with en_i high and load_i low, the block computes the new sample s = sat(rnd(c·y[n−1]) − y[n−2]). Here c is Q2.14, the states are Q1.15, and rnd adds 2^13 to the 32-bit product and keeps its bits above bit 13 (floor after the half-LSB bias). The state then becomes y[n−1] = s and y[n−2] = the old y[n−1].
- R4: The subtraction saturates: results above 32767 give 32767, and results below −32768 give −32768. It never wraps.
- R5: On an edge with en_i and load_i both low, both state registers and y_o keep their values and valid_o goes to 0.
- R6: valid_o is 1 in the cycle after each edge that performed a step, and y_o then shows the new sample.
- R7: When load_i and en_i are both high on the same edge, the load wins: no step is taken and valid_o is 0 afterwards.
- R8: With c = round(2·cos W·2^14), y[n−1] = 0 and y[n−2] = round(−A·sin W·2^15)/2^15, the n-th enabled output stays within 200 LSB of A·sin(W·(n+1)) for 64 samples (A = 16000 LSB, W = 2π/32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Writes the coefficient and both states |
| en_i | input | 1 | Sample enable; advances the recursion one step |
| coef_i | input | 16 | Coefficient 2·cos W, signed Q2.14 |
| init_prev_i | input | 16 | Initial y[n−1], signed Q1.15 |
| init_prev2_i | input | 16 | Initial y[n−2], signed Q1.15 |
| y_o | output | 16 | Current sample (the y[n−1] register), signed Q1.15 |
| valid_o | output | 1 | High for one cycle after each step |

## Verification
A load and a sample step can be requested on the same edge. The design must let the load win and drop the step completely.

This overlap is provoked in two ways:
- a directed case, where the coefficient and states loaded on that edge differ from the running ones;
- the random phase, where load and enable are drawn independently, so the two coincide many times.

Each coincidence is judged at the ports:
- in the following cycle, valid_o must be low and y_o must equal the freshly loaded y[n−1];
- the next enabled sample must match the bench model started from the loaded values, not from the discarded step.

// File: rtl/res_osc_pkg.sv
package res_osc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } res_op_e;
endpackage

// File: rtl/res_osc_ctrl.sv
module res_osc_ctrl
  import res_osc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    load_i,
  input  logic    en_i,
  output res_op_e op_o,
  output logic    valid_o
);
  // load has priority over a step in the same cycle
  always_comb begin
    if (load_i)    op_o = OP_LOAD;
    else if (en_i) op_o = OP_STEP;
    else           op_o = OP_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= (op_o == OP_STEP);
  end

  assert_load_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !valid_o);
  assert_valid_after_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> valid_o);
  assert_idle_no_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> !valid_o);
endmodule

// File: rtl/res_osc_mac.sv
module res_osc_mac #(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  localparam int PROD_W   = DATA_W + COEF_W,
  localparam int RND_W    = PROD_W + 1 - COEF_FRAC
) (
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic signed [DATA_W-1:0] y1_i,
  output logic signed [RND_W-1:0]  rnd_o
);
  localparam logic [PROD_W:0] HALF = (PROD_W+1)'(2**(COEF_FRAC-1));

  logic signed [PROD_W-1:0] prod;
  logic        [PROD_W:0]   prod_b;

  assign prod   = coef_i * y1_i;
  // half-LSB bias, then drop the fraction bits (floor)
  assign prod_b = {prod[PROD_W-1], prod} + HALF;
  assign rnd_o  = $signed(prod_b[PROD_W:COEF_FRAC]);
endmodule

// File: rtl/res_osc_sat_sub.sv
module res_osc_sat_sub #(
  parameter int DATA_W = 16,
  parameter int RND_W  = 19,
  localparam int DIFF_W = RND_W + 1,
  localparam int EXT_W  = DIFF_W - DATA_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [RND_W-1:0]  a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [DATA_W-1:0] res_o
);
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DIFF_W-1:0] diff;
  logic              ovf;

  assign diff = {a_i[RND_W-1], a_i} - {{EXT_W{b_i[DATA_W-1]}}, b_i};
  // overflow when the bits above the result sign do not all match it
  assign ovf  = !((&diff[DIFF_W-1:DATA_W-1]) || !(|diff[DIFF_W-1:DATA_W-1]));

  always_comb begin
    if (!ovf)               res_o = $signed(diff[DATA_W-1:0]);
    else if (diff[DIFF_W-1]) res_o = $signed(MIN_V);
    else                    res_o = $signed(MAX_V);
  end

  assert_sat_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o[DATA_W-1] == diff[DIFF_W-1]);
endmodule

// File: rtl/res_osc_state.sv
module res_osc_state
  import res_osc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  res_op_e                  op_i,
  input  logic signed [COEF_W-1:0] coef_ld_i,
  input  logic signed [DATA_W-1:0] y1_ld_i,
  input  logic signed [DATA_W-1:0] y2_ld_i,
  input  logic signed [DATA_W-1:0] y_next_i,
  output logic signed [COEF_W-1:0] coef_q_o,
  output logic signed [DATA_W-1:0] y1_q_o,
  output logic signed [DATA_W-1:0] y2_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q_o <= '0;
      y1_q_o   <= '0;
      y2_q_o   <= '0;
    end else begin
      unique case (op_i)
        OP_LOAD: begin
          coef_q_o <= coef_ld_i;
          y1_q_o   <= y1_ld_i;
          y2_q_o   <= y2_ld_i;
        end
        OP_STEP: begin
          y1_q_o <= y_next_i;
          y2_q_o <= y1_q_o;
        end
        default: ;
      endcase
    end
  end

  assert_state_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_STEP) |=> (y2_q_o == $past(y1_q_o)) && $stable(coef_q_o));
  assert_load_all_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD) |=> (y1_q_o == $past(y1_ld_i)) && (y2_q_o == $past(y2_ld_i))
                          && (coef_q_o == $past(coef_ld_i)));
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_IDLE) |=> $stable(y1_q_o) && $stable(y2_q_o) && $stable(coef_q_o));
endmodule

// File: rtl/res_osc.sv
module res_osc
  import res_osc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  localparam int RND_W    = DATA_W + COEF_W + 1 - COEF_FRAC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              en_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic [DATA_W-1:0] init_prev_i,
  input  logic [DATA_W-1:0] init_prev2_i,
  output logic [DATA_W-1:0] y_o,
  output logic              valid_o
);
  res_op_e                  op;
  logic signed [COEF_W-1:0] coef_q;
  logic signed [DATA_W-1:0] y1_q, y2_q, y_next;
  logic signed [RND_W-1:0]  rnd;

  res_osc_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .en_i    (en_i),
    .op_o    (op),
    .valid_o (valid_o)
  );

  res_osc_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) u_mac (
    .coef_i (coef_q),
    .y1_i   (y1_q),
    .rnd_o  (rnd)
  );

  res_osc_sat_sub #(.DATA_W(DATA_W), .RND_W(RND_W)) u_sub (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (rnd),
    .b_i    (y2_q),
    .res_o  (y_next)
  );

  res_osc_state #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .coef_ld_i ($signed(coef_i)),
    .y1_ld_i   ($signed(init_prev_i)),
    .y2_ld_i   ($signed(init_prev2_i)),
    .y_next_i  (y_next),
    .coef_q_o  (coef_q),
    .y1_q_o    (y1_q),
    .y2_q_o    (y2_q)
  );

  assign y_o = y1_q;

  assert_step_output_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> (y_o == $past(y_next)));
endmodule

// File: tb/res_osc_bench.sv
`timescale 1ns/1ps
module res_osc_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0, en_i = 1'b0;
  logic [15:0] coef_i = '0, init_prev_i = '0, init_prev2_i = '0;
  logic [15:0] y_o;
  logic        valid_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_c = 0, m_y1 = 0, m_y2 = 0, m_v = 0;

  always #4 clk_i = ~clk_i;

  res_osc u_res_osc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .en_i(en_i),
    .coef_i(coef_i), .init_prev_i(init_prev_i), .init_prev2_i(init_prev2_i),
    .y_o(y_o), .valid_o(valid_o)
  );

  function automatic int f_next(int c, int p1, int p2);
    longint p;
    longint d;
    p = longint'(c) * longint'(p1);
    p = (p + 64'sd8192) >>> 14;
    d = p - longint'(p2);
    if (d > 32767)  d = 32767;
    if (d < -32768) d = -32768;
    return int'(d);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(bit ld, bit en, int c, int a, int b);
    string tag;
    load_i = ld; en_i = en;
    coef_i = 16'(c); init_prev_i = 16'(a); init_prev2_i = 16'(b);
    @(posedge clk_i);
    if (ld) begin
      m_c = c; m_y1 = a; m_y2 = b; m_v = 0;
      tag = en ? "R7" : "R2";
    end else if (en) begin
      int n;
      n = f_next(m_c, m_y1, m_y2);
      m_y2 = m_y1; m_y1 = n; m_v = 1;
      tag = "R3/R4";
    end else begin
      m_v = 0;
      tag = "R5";
    end
    @(negedge clk_i);
    chk({tag, " y_o"}, int'($signed(y_o)), m_y1);
    chk(en && !ld ? "R6 valid" : {tag, " valid"}, int'(valid_o), m_v);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    real w, a_amp, ideal;
    int c0, b0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk("R1 y_o", int'($signed(y_o)), 0);
    chk("R1 valid", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: state is zero after reset, so a step yields 0
    step(0, 1, 0, 0, 0);

    // R3 rounding ties: +0.5 LSB rounds up, -0.5 LSB rounds to 0
    step(1, 0, 1, 8192, 0);
    step(0, 1, 0, 0, 0);
    chk("R3 round up", int'($signed(y_o)), 1);
    step(1, 0, 1, -8192, 0);
    step(0, 1, 0, 0, 0);
    chk("R3 round tie", int'($signed(y_o)), 0);

    // R4 positive and negative saturation
    step(1, 0, 32767, 32767, -32768);
    step(0, 1, 0, 0, 0);
    chk("R4 pos sat", int'($signed(y_o)), 32767);
    step(0, 1, 0, 0, 0);
    step(1, 0, -32768, 32767, 32767);
    step(0, 1, 0, 0, 0);
    chk("R4 neg sat", int'($signed(y_o)), -32768);

    // R5: idle cycles leave the state as is, seen through the next step
    step(1, 0, 20000, 1000, -500);
    step(0, 1, 0, 0, 0);
    repeat (3) step(0, 0, 111, 222, 333);
    step(0, 1, 0, 0, 0);

    // R7: load and enable on the same edge
    step(0, 1, 0, 0, 0);
    step(1, 1, 30000, 4000, 2000);
    step(0, 1, 0, 0, 0);

    // R8: pure tone
    w = 2.0 * 3.14159265358979 / 32.0;
    a_amp = 16000.0;
    c0 = $rtoi(2.0 * $cos(w) * 16384.0 + 0.5);
    b0 = -$rtoi(a_amp * $sin(w) + 0.5);
    step(1, 0, c0, 0, b0);
    for (int n = 0; n < 64; n++) begin
      int d;
      step(0, 1, 0, 0, 0);
      ideal = a_amp * $sin(w * real'(n + 1));
      d = int'($signed(y_o)) - $rtoi(ideal);
      if (d < 0) d = -d;
      chk("R8 tone error within 200", (d <= 200) ? 1 : 0, 1);
    end

    // random mix
    for (int i = 0; i < 600; i++) begin
      bit ld, en;
      ld = ($urandom % 100) < 8;
      en = ($urandom % 100) < 70;
      step(ld, en, int'($signed(16'($urandom))), int'($signed(16'($urandom))),
           int'($signed(16'($urandom))));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule